// File: doc/BRIEF.md
# Tree-Walking Huffman Decoder

This block expands a Huffman-coded stream into packed fixed-width symbols. A single 32-bit input stream with a valid/ready handshake carries a complete job: a header word, then the words that hold the tree, then the coded bitstream. The block keeps the tree bytes in a local byte store. It then walks that tree one bitstream bit per clock. Each leaf it reaches yields one symbol, and it packs the symbols into 32-bit result words. The result words leave on a second valid/ready interface.

Each tree node is a single byte. Its low six bits give a child-pair offset and its two top bits mark which children are leaves. A child address is always formed from the parent's address with bit 0 cleared. A job ends with a one-cycle `done` pulse. The `fault` output reports why a job ended early and holds that code until the next header is accepted. After `done`, the next input word is read as the header of a new job.

Top module: `huf_tree_decoder`

## Requirements
- R1: Header word bits 31:8 hold a byte count C and bits 3:0 a width field. A job emits ceil(C/4) result words. With C = 0 the tree words are taken, no bitstream word is taken, and `done` pulses with no result word.
- R2: A width field of 0 decodes with 8-bit symbols.
- R3: A width field whose value is not 0, 2, 4 or 8 (for example 1, 3 or 15) takes only the header word. It produces no result word, pulses `done` and sets `fault` to 1.
- R4: The words after the header carry bytes in little-endian lane order, starting at tree byte index 0. Byte 0 holds a size value n. Bytes 1 to 2n+1 are the tree, and byte 1 is the root. The bitstream starts with the word after the one that holds byte 2n+1.
- R5: In a node byte at index k, bit 7 marks the left child as a leaf, bit 6 marks the right child as a leaf, and bits 5:0 hold an offset f. The left child is at (k with bit 0 cleared) + 2f + 2 and the right child is at the next index.
- R6: Each bitstream word is used MSB first. A 0 bit selects the left child and a 1 bit selects the right child.
- R7: On reaching a leaf, the leaf byte ANDed with (2^width − 1) is the symbol, and the next bit starts again at the root.
- R8: Symbols fill a result word from bit 0 upward. A word is offered once its 32 bits are full.
- R9: Bits left in the last bitstream word after the final result word are dropped. The next input word is taken as a new header.
- R10: A child index above 2n+1 sets `fault` to 2, stops the job with no further result word, and pulses `done`.
- R11: `done` is high for exactly one cycle per job. `fault` reads 0 after reset and after a job that completes normally.
- R12: While `out_valid` is high and `out_ready` is low, `out_data` and `out_valid` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block takes the input word |
| in_data | input | 32 | Header, tree bytes or bitstream word |
| out_valid | output | 1 | Result word offered |
| out_ready | input | 1 | Sink takes the result word |
| out_data | output | 32 | Packed symbols |
| done | output | 1 | One-cycle end-of-job pulse |
| fault | output | 2 | 0 none, 1 bad width, 2 tree index out of range |

## Verification
A corrupted walk position or a wrong child address shows up as a wrong symbol in the very next result word. It can also raise a spurious out-of-range fault within a few bits. An error in the fill count or the remaining count shows at the ports as a result word with misplaced fields, or as one word too many or too few before `done`. A framing error, where the stream is read against the wrong tree or header, corrupts the job that follows. For that reason, jobs with leftover bits and early faults are each followed by a normal job whose words are compared in full.

// File: rtl/huf_pkg.sv
package huf_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    typedef enum logic [2:0] {
        ST_HDR,
        ST_TREE,
        ST_BITS,
        ST_OUT,
        ST_DONE
    } dec_state_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'd0,
        FLT_WIDTH = 2'd1,
        FLT_TREE  = 2'd2
    } fault_e;

    // one tree node byte: leaf flags on top, child-pair offset below
    typedef struct packed {
        logic       leaf_l;
        logic       leaf_r;
        logic [5:0] off;
    } node_t;

    function automatic logic [3:0] eff_width(input logic [3:0] field);
        return (field == 4'd0) ? 4'd8 : field;
    endfunction

    // widths that tile a 32-bit word and are wider than one bit
    function automatic logic width_ok(input logic [3:0] w);
        return (w == 4'd2) || (w == 4'd4) || (w == 4'd8);
    endfunction

endpackage

// File: rtl/huf_tree_ram.sv
module huf_tree_ram
    import huf_pkg::*;
#(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic [$clog2(DEPTH)-3:0] wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_a_addr,
    output logic [7:0]               rd_a_data,
    input  logic [$clog2(DEPTH)-1:0] rd_b_addr,
    output logic [7:0]               rd_b_data
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0] mem    [DEPTH];
    logic [7:0] lane_b [LANES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane_b[l] = wr_data[8*l +: 8];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
                mem[{wr_idx, 2'(l)}] <= lane_b[l];
            end
        end
    end

    assign rd_a_data = mem[rd_a_addr];
    assign rd_b_data = mem[rd_b_addr];

endmodule

// File: rtl/huf_walk.sv
module huf_walk
    import huf_pkg::*;
#(
    parameter int KW = 10
) (
    input  logic [KW-1:0] node_k,
    input  logic [7:0]    node_byte,
    input  logic          dir,
    input  logic [KW-1:0] last_k,
    output logic [KW-1:0] child,
    output logic          leaf,
    output logic          oob
);
    node_t          nd;
    logic [KW-1:0]  pair;

    assign nd    = node_t'(node_byte);
    // pair base comes from the even-aligned parent address
    assign pair  = {node_k[KW-1:1], 1'b0} + KW'({nd.off, 1'b0}) + KW'(2);
    assign child = pair + {{(KW-1){1'b0}}, dir};
    assign leaf  = dir ? nd.leaf_r : nd.leaf_l;
    assign oob   = child > last_k;

endmodule

// File: rtl/huf_packer.sv
module huf_packer
    import huf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid,
    input  logic [7:0]        sym,
    input  logic [3:0]        width,
    input  logic              clear,
    output logic [WORD_W-1:0] acc,
    output logic              closes
);
    logic [5:0]        fill;
    logic [8:0]        msk;
    logic [7:0]        sym_m;
    logic [WORD_W-1:0] placed;

    assign msk    = (9'd1 << width) - 9'd1;
    assign sym_m  = sym & msk[7:0];
    assign placed = WORD_W'(sym_m) << fill[4:0];
    assign closes = sym_valid && ((fill + {2'b00, width}) == 6'(WORD_W));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc  <= '0;
            fill <= '0;
        end else if (sym_valid) begin
            acc  <= acc | placed;
            fill <= fill + {2'b00, width};
        end
    end

    // R8: the fill pointer never runs past one word
    a_r8_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill <= 6'(WORD_W));

    // R8: a symbol is never added to a word that is already full
    a_r8_no_overfill: assert property (@(posedge clk) disable iff (rst)
        (fill == 6'(WORD_W)) |-> !sym_valid);

endmodule

// File: rtl/huf_tree_decoder.sv
module huf_tree_decoder
    import huf_pkg::*;
#(
    parameter int TREE_BYTES = 512
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              done,
    output logic [1:0]        fault
);
    localparam int AW  = $clog2(TREE_BYTES);
    localparam int WIX = AW - 2;
    localparam int KW  = (AW >= 8) ? AW + 1 : 9;

    dec_state_e         st;
    fault_e             fault_q;
    logic [23:0]        remaining;
    logic [3:0]         width;
    logic [KW-1:0]      last_k, node_k;
    logic [WIX-1:0]     widx;
    logic [WORD_W-1:0]  sh;
    logic [5:0]         bits_left;

    logic               accept, step;
    logic [3:0]         hdr_w;
    logic [KW-1:0]      first_last, cur_last;
    logic               tree_end;
    logic [7:0]         node_byte, leaf_byte;
    logic [KW-1:0]      child;
    logic               leaf, oob;
    logic               sym_valid, pk_clear, pk_closes;
    logic [WORD_W-1:0]  pk_acc;

    assign in_ready   = (st == ST_HDR) || (st == ST_TREE) ||
                        ((st == ST_BITS) && (bits_left == 6'd0));
    assign accept     = in_valid && in_ready;
    assign step       = (st == ST_BITS) && (bits_left != 6'd0);
    assign hdr_w      = eff_width(in_data[3:0]);
    assign first_last = KW'({in_data[7:0], 1'b1});
    assign cur_last   = (widx == '0) ? first_last : last_k;
    assign tree_end   = KW'({widx, 2'b11}) >= cur_last;
    assign sym_valid  = step && leaf && !oob;
    assign pk_clear   = ((st == ST_OUT) && out_ready) || (st == ST_DONE);

    huf_tree_ram #(.DEPTH(TREE_BYTES)) u_ram (
        .clk       (clk),
        .wr_en     ((st == ST_TREE) && accept),
        .wr_idx    (widx),
        .wr_data   (in_data),
        .rd_a_addr (node_k[AW-1:0]),
        .rd_a_data (node_byte),
        .rd_b_addr (child[AW-1:0]),
        .rd_b_data (leaf_byte)
    );

    huf_walk #(.KW(KW)) u_walk (
        .node_k    (node_k),
        .node_byte (node_byte),
        .dir       (sh[WORD_W-1]),
        .last_k    (last_k),
        .child     (child),
        .leaf      (leaf),
        .oob       (oob)
    );

    huf_packer u_pack (
        .clk       (clk),
        .rst       (rst),
        .sym_valid (sym_valid),
        .sym       (leaf_byte),
        .width     (width),
        .clear     (pk_clear),
        .acc       (pk_acc),
        .closes    (pk_closes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_HDR;
            fault_q   <= FLT_NONE;
            remaining <= '0;
            width     <= 4'd8;
            last_k    <= '0;
            node_k    <= KW'(1);
            widx      <= '0;
            sh        <= '0;
            bits_left <= '0;
        end else begin
            unique case (st)
                ST_HDR: if (accept) begin
                    width     <= hdr_w;
                    remaining <= in_data[31:8];
                    widx      <= '0;
                    if (width_ok(hdr_w)) begin
                        fault_q <= FLT_NONE;
                        st      <= ST_TREE;
                    end else begin
                        fault_q <= FLT_WIDTH;
                        st      <= ST_DONE;
                    end
                end
                ST_TREE: if (accept) begin
                    widx <= widx + 1'b1;
                    if (widx == '0) last_k <= first_last;
                    if ((widx == '0) && (first_last >= KW'(TREE_BYTES))) begin
                        fault_q <= FLT_TREE;
                        st      <= ST_DONE;
                    end else if (tree_end) begin
                        node_k    <= KW'(1);
                        bits_left <= '0;
                        st        <= (remaining == '0) ? ST_DONE : ST_BITS;
                    end
                end
                ST_BITS: begin
                    if (accept) begin
                        sh        <= in_data;
                        bits_left <= 6'(WORD_W);
                    end else if (step) begin
                        sh        <= sh << 1;
                        bits_left <= bits_left - 6'd1;
                        if (oob) begin
                            fault_q <= FLT_TREE;
                            st      <= ST_DONE;
                        end else if (leaf) begin
                            node_k <= KW'(1);
                            if (pk_closes) st <= ST_OUT;
                        end else begin
                            node_k <= child;
                        end
                    end
                end
                ST_OUT: if (out_ready) begin
                    if (remaining > 24'd4) begin
                        remaining <= remaining - 24'd4;
                        st        <= ST_BITS;
                    end else begin
                        remaining <= '0;
                        bits_left <= '0;
                        st        <= ST_DONE;
                    end
                end
                ST_DONE: st <= ST_HDR;
                default: st <= ST_HDR;
            endcase
        end
    end

    assign out_valid = (st == ST_OUT);
    assign out_data  = pk_acc;
    assign done      = (st == ST_DONE);
    assign fault     = fault_q;

    // R12: an offered word holds until taken
    a_r12_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R11: the end-of-job pulse lasts one cycle
    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R3: a rejected width never produces a word
    a_r3_width_silent: assert property (@(posedge clk) disable iff (rst)
        (fault == 2'(FLT_WIDTH)) |-> !out_valid);

    // R10: a tree fault never produces a word
    a_r10_tree_silent: assert property (@(posedge clk) disable iff (rst)
        (fault == 2'(FLT_TREE)) |-> !out_valid);

    // R1: a word is offered only while bytes are still owed
    a_r1_word_owed: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (remaining != '0));

    // R4: input is never taken while a result waits
    a_r4_no_input_during_out: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready);

endmodule

// File: tb/sim_huf_tree_decoder.sv
module sim_huf_tree_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [31:0] out_data;
    logic        done;
    logic [1:0]  fault;

    always #5 clk = ~clk;

    huf_tree_decoder u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .done(done), .fault(fault)
    );

    int n_checks = 0;
    int n_err    = 0;

    logic [7:0]  tr       [512];
    int          last;
    logic [7:0]  leaf_sym [128];
    int unsigned code_v   [128];
    int          code_l   [128];
    int          nleaf;

    logic [31:0] inq  [$];
    logic [31:0] expq [$];
    logic [31:0] got  [$];

    int unsigned seed = 32'h1234_5678;
    int unsigned bp_s = 32'h0BAD_F00D;
    bit          bp_on = 1'b0;
    int          done_cnt = 0;
    logic [1:0]  fault_seen = '0;

    task automatic chk(input bit ok, input string msg);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s", msg);
        end
    endtask

    task automatic roll(output int unsigned v);
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        v = seed;
    endtask

    // sink side: choose ready, then record the handshake of the coming edge
    always @(negedge clk) begin
        if (bp_on) begin
            bp_s = bp_s ^ (bp_s << 13);
            bp_s = bp_s ^ (bp_s >> 17);
            bp_s = bp_s ^ (bp_s << 5);
            out_ready = bp_s[7] | bp_s[3];
        end else begin
            out_ready = 1'b1;
        end
        #1;
        if (out_valid && out_ready) got.push_back(out_data);
        if (done) begin
            done_cnt++;
            fault_seen = fault;
        end
    end

    function automatic logic [7:0] wmask(input int w);
        return 8'((1 << w) - 1);
    endfunction

    // balanced tree: node k has its children at 2k and 2k+1
    task automatic build_full(input int d, input int w);
        int half;
        half  = 1 << d;
        last  = 2 * half - 1;
        tr[0] = 8'(half - 1);
        for (int k = 1; k < half; k++) begin
            int off;
            off   = (2 * k - (k & ~1) - 2) / 2;
            tr[k] = ((k >= half / 2) ? 8'hC0 : 8'h00) | 8'(off);
        end
        nleaf = half;
        for (int s = 0; s < half; s++) begin
            logic [7:0] lb;
            lb = (w == 8) ? (8'(s) ^ 8'h5A) : (8'(s) | (8'hFF << w));
            tr[half + s] = lb;
            leaf_sym[s]  = lb & wmask(w);
            code_v[s]    = s;
            code_l[s]    = d;
        end
    endtask

    // right-leaning chain, every offset zero, nodes at odd indices
    task automatic build_chain(input int l, input int w);
        logic [7:0] lb;
        last  = 2 * l + 1;
        tr[0] = 8'(l);
        for (int i = 0; i < l; i++) begin
            tr[2*i+1]   = 8'h80 | ((i == l - 1) ? 8'h40 : 8'h00);
            lb          = 8'(i * 37 + 11);
            tr[2*i+2]   = lb;
            leaf_sym[i] = lb & wmask(w);
            code_v[i]   = (1 << (i + 1)) - 2;
            code_l[i]   = i + 1;
        end
        lb          = 8'(l * 37 + 11);
        tr[2*l+1]   = lb;
        leaf_sym[l] = lb & wmask(w);
        code_v[l]   = (1 << l) - 1;
        code_l[l]   = l;
        nleaf       = l + 1;
    endtask

    task automatic push_header(input int field, input int count);
        inq.push_back({24'(count), 4'h0, 4'(field)});
    endtask

    task automatic push_tree();
        for (int j = 0; j < (last + 4) / 4; j++) begin
            logic [31:0] wd;
            wd = '0;
            for (int b = 0; b < 4; b++) begin
                if (4 * j + b <= last) wd[8*b +: 8] = tr[4*j+b];
            end
            inq.push_back(wd);
        end
    endtask

    task automatic send(input logic [31:0] wd);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = wd;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic exec(input string tag, input logic [1:0] efault, input bit bp);
        int d0;
        d0 = done_cnt;
        got.delete();
        bp_on = bp;
        for (int i = 0; i < inq.size(); i++) begin
            send(inq[i]);
            if (bp && (i % 3 == 2)) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        repeat (2) @(negedge clk);
        bp_on = 1'b0;
        chk(got.size() == expq.size(),
            $sformatf("%s R1 word count got %0d exp %0d", tag, got.size(), expq.size()));
        for (int i = 0; i < expq.size() && i < got.size(); i++) begin
            chk(got[i] === expq[i],
                $sformatf("%s R7 R8 %s word %0d got %h exp %h",
                          tag, bp ? "R12" : "", i, got[i], expq[i]));
        end
        chk(fault_seen === efault,
            $sformatf("%s R11 fault got %0d exp %0d", tag, fault_seen, efault));
        chk(done_cnt == d0 + 1,
            $sformatf("%s R11 done pulses got %0d exp 1", tag, done_cnt - d0));
    endtask

    task automatic run_job(input string tag, input int field, input int count, input bit bp);
        int w, nw, spw;
        bit bq [$];
        w   = (field == 0) ? 8 : field;
        nw  = (count + 3) / 4;
        spw = 32 / w;
        inq.delete();
        expq.delete();
        push_header(field, count);
        push_tree();
        for (int i = 0; i < nw; i++) begin
            logic [31:0] ew;
            ew = '0;
            for (int j = 0; j < spw; j++) begin
                int unsigned r;
                int idx;
                roll(r);
                idx = int'(r % nleaf);
                ew  = ew | (32'(leaf_sym[idx]) << (j * w));
                for (int b = code_l[idx] - 1; b >= 0; b--) bq.push_back(code_v[idx][b]);
            end
            expq.push_back(ew);
        end
        while (bq.size() > 0) begin
            logic [31:0] wd;
            wd = '0;
            for (int b = 0; b < 32; b++) begin
                bit v;
                v  = (bq.size() > 0) ? bq.pop_front() : 1'b1;
                wd = {wd[30:0], v};
            end
            inq.push_back(wd);
        end
        exec(tag, 2'd0, bp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL R11 watchdog expired got no done exp done");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(in_ready === 1'b1, $sformatf("R11 reset in_ready got %b exp 1", in_ready));
        chk(out_valid === 1'b0, $sformatf("R11 reset out_valid got %b exp 0", out_valid));
        chk(done === 1'b0, $sformatf("R11 reset done got %b exp 0", done));
        chk(fault === 2'd0, $sformatf("R11 reset fault got %0d exp 0", fault));

        // R6 R7: two-bit symbols, leaf bytes carry junk above the width
        build_full(2, 2);
        run_job("R6", 2, 16, 1'b0);

        // R4: eight tree words, with backpressure
        build_full(4, 4);
        run_job("R4", 4, 12, 1'b1);

        // R2: width field 0 gives bytes
        build_full(5, 8);
        run_job("R2", 0, 8, 1'b1);

        // R5: offsets of zero from odd parents, uneven codes, count not a multiple of 4
        build_chain(5, 4);
        run_job("R5", 4, 10, 1'b0);

        // R9: leftover bits, then further jobs straight after
        build_chain(3, 8);
        run_job("R9", 8, 20, 1'b1);
        build_chain(6, 2);
        run_job("R9", 2, 7, 1'b0);

        // R3: rejected widths take only the header
        for (int f = 0; f < 3; f++) begin
            inq.delete();
            expq.delete();
            push_header((f == 0) ? 3 : ((f == 1) ? 1 : 15), 8);
            exec("R3", 2'd1, 1'b0);
        end

        // R1: zero count
        build_full(2, 2);
        run_job("R1", 2, 0, 1'b0);

        // R10: root-only tree, any step leaves it
        inq.delete();
        expq.delete();
        push_header(4, 8);
        inq.push_back(32'h0000_0000);
        inq.push_back(32'h0000_0000);
        exec("R10", 2'd2, 1'b0);

        // R10: inner node points past the tree end
        build_full(2, 2);
        tr[3] = 8'h05;
        inq.delete();
        expq.delete();
        push_header(2, 4);
        push_tree();
        inq.push_back(32'h8000_0000);
        exec("R10", 2'd2, 1'b0);

        // R11: a clean job after a fault reports no fault
        build_full(3, 4);
        run_job("R11", 4, 8, 1'b1);

        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule